// File: doc/BRIEF.md
# Adaptive Dead-Time Gate Sequencer

This block sequences the two gate enables of a half-bridge from a single PWM command, where high means the high-side switch should conduct. It never trusts a fixed dead-time alone. Before it turns either switch on, it waits for a digital flag showing that the opposite gate has actually discharged below its threshold. It then waits a further programmable number of clock cycles and only then raises the new enable. The command may reverse at any point, and the sequencer re-targets without ever letting both enables overlap.

Each discharge flag comes from an external comparator and is asynchronous. Both flags pass through a two-flop synchronizer before the sequencer uses them. The two post-sense delays and the sense timeout are read from configuration inputs while reset is held, and they are then frozen until the next reset. If a discharge flag fails to appear within the timeout, the block parks both enables low and raises a sticky fault that only reset clears.

Top module: `dt_gate_seq`

## Requirements
- R1: While reset is held and in the cycle after it is released, `hi_gate_en`, `lo_gate_en` and `sense_fault` are all 0.
- R2: `hi_gate_en` and `lo_gate_en` are never 1 in the same cycle.
- R3: If `hi_gate_en` is 1 and a clock edge samples `pwm_cmd`=0 with `run_en`=1, `hi_gate_en` is 0 after that edge. The low-side turn-off on `pwm_cmd`=1 works the same way.
- R4: A flag value of 1 means the gate is discharged. A turn-on proceeds only after the opposite flag has been seen at 1 through a two-flop synchronizer. A raw flag that rises before edge k can therefore first act at edge k+2.
- R5: Once the high-side discharge flag is seen, `lo_gate_en` rises after `dly_h2l_cfg` further cycles in the delay phase. A value of 0 skips the delay phase.
- R6: The high-side turn-on mirrors R5. It waits on `lo_off_raw` and then uses `dly_l2h_cfg`.
- R7: `dly_h2l_cfg`, `dly_l2h_cfg` and `tmo_cfg` are captured on clock edges where `rst_n`=0. Changing them while `rst_n`=1 has no effect.
- R8: The wait phase counts cycles in which the flag is still 0. On the flagless cycle number `tmo_cfg`+1, the block enters a fault state. In the fault state both enables are 0 and `sense_fault` is 1 until reset, whatever `run_en` and `pwm_cmd` do.
- R9: A command reversal during a wait or delay phase restarts sequencing toward the new target. The restart begins with a fresh wait for the other gate's discharge flag and a cleared timeout count.
- R10: With `run_en`=0 at a clock edge and no fault present, both enables are 0 after that edge. The sequencer then returns to idle. From idle, the first edge with `run_en`=1 starts a wait phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; configuration is loaded while low |
| run_en | input | 1 | Sequencer enable; low forces both gates off |
| pwm_cmd | input | 1 | 1 requests the high-side switch, 0 the low-side switch |
| hi_off_raw | input | 1 | Asynchronous flag, 1 = high-side gate discharged |
| lo_off_raw | input | 1 | Asynchronous flag, 1 = low-side gate discharged |
| dly_h2l_cfg | input | DLY_W | Cycles from high-side discharge seen to low-side enable |
| dly_l2h_cfg | input | DLY_W | Cycles from low-side discharge seen to high-side enable |
| tmo_cfg | input | TMO_W | Sense timeout limit in cycles |
| hi_gate_en | output | 1 | High-side gate enable |
| lo_gate_en | output | 1 | Low-side gate enable |
| sense_fault | output | 1 | Sticky discharge-timeout fault |

## Verification
The hardest conditions to reach from the ports are a command reversal that lands inside a post-sense delay window, and a sense flag that stays stuck so the timeout expires. The bench drives the flags from a small gate model that raises each discharge flag a set number of cycles after its enable drops. A pseudo-random command stream with varying discharge latency then produces reversals in every phase. A stuck-flag switch in the gate model holds a flag at 0, which forces the timeout. The bench then toggles `run_en` and the command to show that the fault holds.

// File: rtl/dt_gate_pkg.sv
package dt_gate_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_WAIT_HI = 3'd1,
        ST_DLY_LO  = 3'd2,
        ST_LO_ON   = 3'd3,
        ST_WAIT_LO = 3'd4,
        ST_DLY_HI  = 3'd5,
        ST_HI_ON   = 3'd6,
        ST_FAULT   = 3'd7
    } seq_state_e;

    function automatic int unsigned cnt_width(int unsigned a, int unsigned b);
        return ((a > b) ? a : b) + 1;
    endfunction

endpackage

// File: rtl/dt_sense_sync.sv
module dt_sense_sync #(
    parameter int unsigned N_FLAGS = 2,
    parameter int unsigned STAGES  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_FLAGS-1:0] raw_i,
    output logic [N_FLAGS-1:0] sync_o
);
    for (genvar g = 0; g < N_FLAGS; g++) begin : g_flag
        logic [STAGES-1:0] pipe_d, pipe_q;

        always_comb begin
            pipe_d = {pipe_q[STAGES-2:0], raw_i[g]};
        end

        always_ff @(posedge clk) begin
            if (!rst_n) pipe_q <= '0;
            else        pipe_q <= pipe_d;
        end

        assign sync_o[g] = pipe_q[STAGES-1];
    end
endmodule

// File: rtl/dt_cfg_latch.sv
module dt_cfg_latch #(
    parameter int unsigned DLY_W = 6,
    parameter int unsigned TMO_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DLY_W-1:0] dly_h2l_i,
    input  logic [DLY_W-1:0] dly_l2h_i,
    input  logic [TMO_W-1:0] tmo_i,
    output logic [DLY_W-1:0] dly_h2l_o,
    output logic [DLY_W-1:0] dly_l2h_o,
    output logic [TMO_W-1:0] tmo_o
);
    typedef struct packed {
        logic [DLY_W-1:0] h2l;
        logic [DLY_W-1:0] l2h;
        logic [TMO_W-1:0] tmo;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (!rst_n) begin
            cfg_d.h2l = dly_h2l_i;
            cfg_d.l2h = dly_l2h_i;
            cfg_d.tmo = tmo_i;
        end
    end

    always_ff @(posedge clk) begin
        cfg_q <= cfg_d;
    end

    assign dly_h2l_o = cfg_q.h2l;
    assign dly_l2h_o = cfg_q.l2h;
    assign tmo_o     = cfg_q.tmo;

    // R7
    cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> $stable(cfg_q));
endmodule

// File: rtl/dt_seq_fsm.sv
module dt_seq_fsm
    import dt_gate_pkg::*;
#(
    parameter int unsigned DLY_W = 6,
    parameter int unsigned TMO_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic             cmd_hi,
    input  logic             hi_off,
    input  logic             lo_off,
    input  logic [DLY_W-1:0] dly_h2l,
    input  logic [DLY_W-1:0] dly_l2h,
    input  logic [TMO_W-1:0] tmo,
    output logic             hi_en,
    output logic             lo_en,
    output logic             fault
);
    localparam int unsigned CW = cnt_width(DLY_W, TMO_W);

    typedef struct packed {
        seq_state_e    st;
        logic [CW-1:0] cnt;
        logic          hi;
        logic          lo;
        logic          flt;
    } seq_t;

    seq_t s_d, s_q;

    logic [CW-1:0] h2l_w, l2h_w, tmo_w;
    assign h2l_w = CW'(dly_h2l);
    assign l2h_w = CW'(dly_l2h);
    assign tmo_w = CW'(tmo);

    always_comb begin
        s_d = s_q;
        if (!run_en && s_q.st != ST_FAULT) begin
            s_d.st  = ST_IDLE;
            s_d.cnt = '0;
        end else begin
            unique case (s_q.st)
                ST_IDLE: begin
                    s_d.cnt = '0;
                    s_d.st  = cmd_hi ? ST_WAIT_LO : ST_WAIT_HI;
                end
                ST_WAIT_HI: begin
                    if (cmd_hi) begin
                        s_d.st  = ST_WAIT_LO;
                        s_d.cnt = '0;
                    end else if (hi_off) begin
                        if (h2l_w == '0) begin
                            s_d.st = ST_LO_ON;
                        end else begin
                            s_d.st  = ST_DLY_LO;
                            s_d.cnt = CW'(1);
                        end
                    end else if (s_q.cnt == tmo_w) begin
                        s_d.st = ST_FAULT;
                    end else begin
                        s_d.cnt = s_q.cnt + 1'b1;
                    end
                end
                ST_DLY_LO: begin
                    if (cmd_hi) begin
                        s_d.st  = ST_WAIT_LO;
                        s_d.cnt = '0;
                    end else if (s_q.cnt >= h2l_w) begin
                        s_d.st = ST_LO_ON;
                    end else begin
                        s_d.cnt = s_q.cnt + 1'b1;
                    end
                end
                ST_LO_ON: begin
                    if (cmd_hi) begin
                        s_d.st  = ST_WAIT_LO;
                        s_d.cnt = '0;
                    end
                end
                ST_WAIT_LO: begin
                    if (!cmd_hi) begin
                        s_d.st  = ST_WAIT_HI;
                        s_d.cnt = '0;
                    end else if (lo_off) begin
                        if (l2h_w == '0) begin
                            s_d.st = ST_HI_ON;
                        end else begin
                            s_d.st  = ST_DLY_HI;
                            s_d.cnt = CW'(1);
                        end
                    end else if (s_q.cnt == tmo_w) begin
                        s_d.st = ST_FAULT;
                    end else begin
                        s_d.cnt = s_q.cnt + 1'b1;
                    end
                end
                ST_DLY_HI: begin
                    if (!cmd_hi) begin
                        s_d.st  = ST_WAIT_HI;
                        s_d.cnt = '0;
                    end else if (s_q.cnt >= l2h_w) begin
                        s_d.st = ST_HI_ON;
                    end else begin
                        s_d.cnt = s_q.cnt + 1'b1;
                    end
                end
                ST_HI_ON: begin
                    if (!cmd_hi) begin
                        s_d.st  = ST_WAIT_HI;
                        s_d.cnt = '0;
                    end
                end
                default: begin
                    s_d.st = ST_FAULT;
                end
            endcase
        end
        s_d.hi  = (s_d.st == ST_HI_ON);
        s_d.lo  = (s_d.st == ST_LO_ON);
        s_d.flt = (s_d.st == ST_FAULT);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.st  <= ST_IDLE;
            s_q.cnt <= '0;
            s_q.hi  <= 1'b0;
            s_q.lo  <= 1'b0;
            s_q.flt <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign hi_en = s_q.hi;
    assign lo_en = s_q.lo;
    assign fault = s_q.flt;

    // R2
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(hi_en && lo_en));
    // R3
    hi_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_en && run_en && !cmd_hi) |=> !hi_en);
    // R3
    lo_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_en && run_en && cmd_hi) |=> !lo_en);
    // R4
    lo_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_WAIT_HI && !hi_off) |=> !lo_en);
    // R4
    hi_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_WAIT_LO && !lo_off) |=> !hi_en);
    // R8
    fault_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> fault);
    // R8
    fault_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (!hi_en && !lo_en));
    // R10
    idle_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> (!hi_en && !lo_en));
endmodule

// File: rtl/dt_gate_seq.sv
module dt_gate_seq #(
    parameter int unsigned DLY_W = 6,
    parameter int unsigned TMO_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic             pwm_cmd,
    input  logic             hi_off_raw,
    input  logic             lo_off_raw,
    input  logic [DLY_W-1:0] dly_h2l_cfg,
    input  logic [DLY_W-1:0] dly_l2h_cfg,
    input  logic [TMO_W-1:0] tmo_cfg,
    output logic             hi_gate_en,
    output logic             lo_gate_en,
    output logic             sense_fault
);
    localparam int unsigned N_FLAGS = 2;
    localparam int unsigned HI_IDX  = 0;
    localparam int unsigned LO_IDX  = 1;

    logic [N_FLAGS-1:0] flags_sync;
    logic [DLY_W-1:0]   h2l_q, l2h_q;
    logic [TMO_W-1:0]   tmo_q;

    dt_sense_sync #(.N_FLAGS(N_FLAGS), .STAGES(2)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  ({lo_off_raw, hi_off_raw}),
        .sync_o (flags_sync)
    );

    dt_cfg_latch #(.DLY_W(DLY_W), .TMO_W(TMO_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .dly_h2l_i (dly_h2l_cfg),
        .dly_l2h_i (dly_l2h_cfg),
        .tmo_i     (tmo_cfg),
        .dly_h2l_o (h2l_q),
        .dly_l2h_o (l2h_q),
        .tmo_o     (tmo_q)
    );

    dt_seq_fsm #(.DLY_W(DLY_W), .TMO_W(TMO_W)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_en  (run_en),
        .cmd_hi  (pwm_cmd),
        .hi_off  (flags_sync[HI_IDX]),
        .lo_off  (flags_sync[LO_IDX]),
        .dly_h2l (h2l_q),
        .dly_l2h (l2h_q),
        .tmo     (tmo_q),
        .hi_en   (hi_gate_en),
        .lo_en   (lo_gate_en),
        .fault   (sense_fault)
    );
endmodule

// File: tb/dt_gate_seq_test.sv
`timescale 1ns/1ps
module dt_gate_seq_test;
    localparam int DLY_W = 6;
    localparam int TMO_W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic run_en = 1'b0;
    logic pwm_cmd = 1'b0;
    logic hi_off_raw = 1'b0;
    logic lo_off_raw = 1'b0;
    logic [DLY_W-1:0] dly_h2l_cfg = 6'd5;
    logic [DLY_W-1:0] dly_l2h_cfg = 6'd3;
    logic [TMO_W-1:0] tmo_cfg = 8'd20;
    logic hi_gate_en, lo_gate_en, sense_fault;

    always #2.5 clk = ~clk;

    dt_gate_seq #(.DLY_W(DLY_W), .TMO_W(TMO_W)) uut (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .pwm_cmd(pwm_cmd),
        .hi_off_raw(hi_off_raw), .lo_off_raw(lo_off_raw),
        .dly_h2l_cfg(dly_h2l_cfg), .dly_l2h_cfg(dly_l2h_cfg), .tmo_cfg(tmo_cfg),
        .hi_gate_en(hi_gate_en), .lo_gate_en(lo_gate_en), .sense_fault(sense_fault)
    );

    int checks = 0;
    int failures = 0;
    string tag = "R1";

    // gate plant: flag rises k cycles after the enable drops
    int plant_k = 2;
    bit stuck_h = 0, stuck_l = 0;
    int h_low = 0, l_low = 0;

    // behavioural reference
    string m_phase = "idle";
    int m_wait = 0, m_rem = 0;
    int m_h2l = 0, m_l2h = 0, m_tmo = 0;
    bit m_hi = 0, m_lo = 0, m_flt = 0;
    bit sh [$];
    bit sl [$];

    task automatic chk(input bit ok, input string t, input int act, input int exp_v);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s act=%0d exp=%0d at %0t", t, act, exp_v, $time);
        end
    endtask

    task automatic begin_turn_on(input bit to_hi);
        int d = to_hi ? m_l2h : m_h2l;
        if (d == 0) m_phase = to_hi ? "hion" : "loon";
        else begin m_phase = to_hi ? "dlyh" : "dlyl"; m_rem = d; end
    endtask

    task automatic model_step();
        bit seen_h, seen_l;
        seen_h = sh[0];
        seen_l = sl[0];
        if (!rst_n) begin
            m_phase = "idle"; m_wait = 0;
            m_h2l = dly_h2l_cfg; m_l2h = dly_l2h_cfg; m_tmo = tmo_cfg;
            sh = '{0, 0}; sl = '{0, 0};
        end else begin
            void'(sh.pop_front()); sh.push_back(hi_off_raw);
            void'(sl.pop_front()); sl.push_back(lo_off_raw);
            if (m_phase == "fault") begin
                m_phase = "fault";
            end else if (!run_en) begin
                m_phase = "idle";
            end else if (m_phase == "idle") begin
                m_phase = pwm_cmd ? "waitl" : "waith"; m_wait = 0;
            end else if (pwm_cmd && (m_phase == "waith" || m_phase == "dlyl" || m_phase == "loon")) begin
                m_phase = "waitl"; m_wait = 0;
            end else if (!pwm_cmd && (m_phase == "waitl" || m_phase == "dlyh" || m_phase == "hion")) begin
                m_phase = "waith"; m_wait = 0;
            end else if (m_phase == "waith" || m_phase == "waitl") begin
                if ((m_phase == "waith") ? seen_h : seen_l)
                    begin_turn_on(m_phase == "waitl");
                else begin
                    m_wait++;
                    if (m_wait > m_tmo) m_phase = "fault";
                end
            end else if (m_phase == "dlyl" || m_phase == "dlyh") begin
                m_rem--;
                if (m_rem == 0) m_phase = (m_phase == "dlyh") ? "hion" : "loon";
            end
        end
        m_hi  = (m_phase == "hion");
        m_lo  = (m_phase == "loon");
        m_flt = (m_phase == "fault");
    endtask

    task automatic step();
        h_low = m_hi ? 0 : h_low + 1;
        l_low = m_lo ? 0 : l_low + 1;
        hi_off_raw = (h_low >= plant_k) && !stuck_h;
        lo_off_raw = (l_low >= plant_k) && !stuck_l;
        model_step();
        @(posedge clk);
        #1;
        chk(hi_gate_en == m_hi, {tag, " hi_gate_en"}, hi_gate_en, m_hi);
        chk(lo_gate_en == m_lo, {tag, " lo_gate_en"}, lo_gate_en, m_lo);
        chk(sense_fault == m_flt, {tag, " sense_fault"}, sense_fault, m_flt);
        // R2
        chk(!(hi_gate_en && lo_gate_en), "R2 overlap", hi_gate_en & lo_gate_en, 0);
    endtask

    task automatic steps(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        steps(3);
        chk(!hi_gate_en && !lo_gate_en && !sense_fault, "R1 in reset",
            {hi_gate_en, lo_gate_en, sense_fault}, 0);
        rst_n = 1'b1;
        step();
        chk(!hi_gate_en && !lo_gate_en && !sense_fault, "R1 after release",
            {hi_gate_en, lo_gate_en, sense_fault}, 0);
    endtask

    initial begin
        int cyc;
        bit [15:0] lfsr;
        sh = '{0, 0}; sl = '{0, 0};
        #1;
        tag = "R1";
        do_reset();

        tag = "R5"; run_en = 1; pwm_cmd = 0;
        steps(20);
        chk(lo_gate_en == 1, "R5 low side on", lo_gate_en, 1);

        tag = "R3"; pwm_cmd = 1;
        step();
        chk(lo_gate_en == 0, "R3 low drops first", lo_gate_en, 0);
        tag = "R6";
        steps(15);
        chk(hi_gate_en == 1, "R6 high side on", hi_gate_en, 1);
        tag = "R3"; pwm_cmd = 0;
        step();
        chk(hi_gate_en == 0, "R3 high drops first", hi_gate_en, 0);

        // R4: held flag means low side must stay off
        tag = "R4"; stuck_h = 1;
        steps(10);
        chk(lo_gate_en == 0, "R4 waits for flag", lo_gate_en, 0);
        stuck_h = 0;
        steps(12);
        chk(lo_gate_en == 1, "R4 proceeds after flag", lo_gate_en, 1);

        // R9: reversals during delay phases
        tag = "R9"; pwm_cmd = 1;
        steps(5); pwm_cmd = 0; steps(4); pwm_cmd = 1; steps(3); pwm_cmd = 0;
        steps(20);
        chk(lo_gate_en == 1, "R9 settles low", lo_gate_en, 1);

        // R7: configuration changes outside reset are ignored
        tag = "R7"; dly_h2l_cfg = 0; dly_l2h_cfg = 40; tmo_cfg = 1;
        pwm_cmd = 1; steps(20); pwm_cmd = 0; steps(20);

        // R10
        tag = "R10"; pwm_cmd = 1; steps(15); run_en = 0;
        step();
        chk(!hi_gate_en && !lo_gate_en, "R10 disable", {hi_gate_en, lo_gate_en}, 0);
        steps(4); run_en = 1; steps(15);

        // R8: stuck low-side flag drives timeout
        tag = "R8"; dly_h2l_cfg = 5; dly_l2h_cfg = 3; tmo_cfg = 20;
        do_reset();
        tag = "R8"; run_en = 1; pwm_cmd = 0; steps(20);
        stuck_l = 1; pwm_cmd = 1;
        steps(30);
        chk(sense_fault == 1, "R8 fault raised", sense_fault, 1);
        run_en = 0; steps(3); run_en = 1; pwm_cmd = 0; steps(10);
        chk(sense_fault == 1 && !lo_gate_en && !hi_gate_en, "R8 fault sticky",
            {sense_fault, hi_gate_en, lo_gate_en}, 4);
        stuck_l = 0;

        // zero delays
        tag = "R5"; dly_h2l_cfg = 0; dly_l2h_cfg = 0; tmo_cfg = 8;
        do_reset();
        tag = "R6"; run_en = 1; pwm_cmd = 1; steps(10);
        pwm_cmd = 0; steps(10); pwm_cmd = 1; steps(10);

        // pseudo-random command and plant latency
        tag = "R9"; dly_h2l_cfg = 4; dly_l2h_cfg = 2; tmo_cfg = 12;
        do_reset();
        tag = "R9"; run_en = 1;
        lfsr = 16'hACE1;
        for (cyc = 0; cyc < 600; cyc++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (lfsr[3:0] == 4'd0) pwm_cmd = ~pwm_cmd;
            if (lfsr[9:5] == 5'd0) run_en = ~run_en;
            plant_k = int'(lfsr[12:11]);
            step();
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog act=0 exp=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule